// File: doc/BRIEF.md
# Coherence State Select and Write-Command Decoder

This block is the last stage of a directory controller pipeline. For each message it picks the coherence state to work on, together with that line's owner and sharer set. The candidates are the tag-array copy, the pending-transaction table copy, the replacement message itself, or "not present". The block then turns the protocol's next-state answer and its action flags into write commands. One set of commands goes to the pending-transaction table: allocate, release or modify an entry. The other set goes to the line array: allocate, release or rewrite a way. It also raises a strobe that pushes an evicted line into the replacement queue.

A line in a transient state lives only in the transaction table. A line in a stable state lives only in the array. The two command sets therefore mirror each other. A line that enters a transient state is released from the array. A line that settles is written back into the array, unless it settles as not-present with its way flagged for invalidation. On a replacement the victim way is never invalidated. The new line overwrites it in place, and the old contents go to the replacement queue. All results are registered, so they appear one clock after the inputs.

Top module: `coh_state_decoder`

## Requirements
- R1: The selected state, owner and sharers come from the cache copy when `cache_hit` is 1. Otherwise they come from the TSHR copy when `tshr_hit` is 1. Otherwise they come from the message copy when `is_repl` is 1. Otherwise the state is N (code 0) and owner and sharers are zero.
- R2: State codes are 3 bits wide. Codes 0 (N), 1 (I), 2 (S) and 3 (M) are stable. Codes 4 (share-wait), 5 (own-wait), 6 (evict-wait) and 7 (fill-wait) are transient.
- R3: TSHR allocate fires when the selected state is stable and the next state is transient. TSHR release fires when the selected state is transient and the next state is stable. TSHR modify fires when both are transient and `info_en` is 1.
- R4: Cache update fires when the selected and next states are both stable, `cache_hit` is 1, and `info_en` or `store_data` is 1.
- R5: Cache allocate fires when all of these hold: the next state is stable; `info_en` or `store_data` is 1; a TSHR release does not coincide with `inval_way`; no cache update fires.
- R6: Cache deallocate fires exactly when TSHR allocate fires and `cache_hit` is 1.
- R7: Replacement enqueue fires when a cache allocate fires, `cache_hit` is 0 and `way_valid` is 1. In that case no cache deallocate is raised, because the victim is overwritten in place.
- R8: Every strobe is 0 when `msg_valid` was 0. All outputs appear one clock after their inputs and are 0 after reset.
- R9: Cache allocate and cache update never fire together, and at most one TSHR command fires at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_valid | input | 1 | Current message is valid |
| cache_hit | input | 1 | Line hit in the cache array |
| way_valid | input | 1 | Chosen cache way already holds a valid line |
| tshr_hit | input | 1 | Line hit in the TSHR |
| is_repl | input | 1 | Message is a replacement |
| cache_state | input | 3 | State from cache |
| cache_owner | input | OWNER_W | Owner from cache |
| cache_sharers | input | SHARER_W | Sharer mask from cache |
| tshr_state | input | 3 | State from TSHR |
| tshr_owner | input | OWNER_W | Owner from TSHR |
| tshr_sharers | input | SHARER_W | Sharer mask from TSHR |
| msg_state | input | 3 | State carried by message |
| msg_owner | input | OWNER_W | Owner carried by message |
| msg_sharers | input | SHARER_W | Sharer mask carried by message |
| next_state | input | 3 | Next state chosen by the protocol |
| info_en | input | 1 | Coherence info update enable |
| store_data | input | 1 | Protocol asks to store data |
| inval_way | input | 1 | Protocol asks to invalidate the way |
| sel_state | output | 3 | Selected state |
| sel_owner | output | OWNER_W | Selected owner |
| sel_sharers | output | SHARER_W | Selected sharer mask |
| tshr_alloc | output | 1 | TSHR entry allocate |
| tshr_release | output | 1 | TSHR entry deallocate |
| tshr_modify | output | 1 | TSHR entry update |
| cache_alloc | output | 1 | Cache entry allocate |
| cache_dealloc | output | 1 | Cache entry deallocate |
| cache_update | output | 1 | Cache entry update |
| repl_enq | output | 1 | Push victim line to replacement queue |

## Verification
The hardest case to reach is the replacement push. It needs a valid message that misses the array, lands on a valid way, and settles into a stable state with data to store. It also needs no TSHR release paired with invalidation. Uniform random inputs meet all of these together only rarely. The stimulus therefore includes directed vectors for that case. It also biases the random draws toward stable next states and asserted update flags, so that the allocate-without-hit path comes up often. A second directed vector pairs a TSHR release with the invalidate flag to show that the allocation is suppressed.

// File: rtl/coh_dec_pkg.sv
package coh_dec_pkg;
   localparam int STATE_W    = 3;
   localparam int NUM_STATES = 1 << STATE_W;

   typedef enum logic [STATE_W-1:0] {
      ST_N          = 3'd0,
      ST_I          = 3'd1,
      ST_S          = 3'd2,
      ST_M          = 3'd3,
      ST_SHARE_WAIT = 3'd4,
      ST_OWN_WAIT   = 3'd5,
      ST_EVICT_WAIT = 3'd6,
      ST_FILL_WAIT  = 3'd7
   } coh_state_e;

   // bit k set: state code k is stable
   localparam logic [NUM_STATES-1:0] DEFAULT_STABLE_MASK = 8'b0000_1111;

   typedef struct packed {
      logic tshr_alloc;
      logic tshr_release;
      logic tshr_modify;
      logic cache_alloc;
      logic cache_dealloc;
      logic cache_update;
      logic repl_enq;
   } wr_cmd_t;
endpackage

// File: rtl/coh_stable_lut.sv
module coh_stable_lut
   import coh_dec_pkg::*;
#(
   parameter logic [NUM_STATES-1:0] STABLE_MASK = DEFAULT_STABLE_MASK
) (
   input  logic [STATE_W-1:0] code,
   output logic               stable
);
   logic [NUM_STATES-1:0] table_q;

   genvar k;
   generate
      for (k = 0; k < NUM_STATES; k++) begin : g_entry
         assign table_q[k] = STABLE_MASK[k];
      end
   endgenerate

   assign stable = table_q[code];
endmodule

// File: rtl/coh_state_select.sv
module coh_state_select
   import coh_dec_pkg::*;
#(
   parameter int OWNER_W  = 4,
   parameter int SHARER_W = 8
) (
   input  logic                cache_hit,
   input  logic                tshr_hit,
   input  logic                is_repl,
   input  logic [STATE_W-1:0]  cache_state,
   input  logic [OWNER_W-1:0]  cache_owner,
   input  logic [SHARER_W-1:0] cache_sharers,
   input  logic [STATE_W-1:0]  tshr_state,
   input  logic [OWNER_W-1:0]  tshr_owner,
   input  logic [SHARER_W-1:0] tshr_sharers,
   input  logic [STATE_W-1:0]  msg_state,
   input  logic [OWNER_W-1:0]  msg_owner,
   input  logic [SHARER_W-1:0] msg_sharers,
   output logic [STATE_W-1:0]  pick_state,
   output logic [OWNER_W-1:0]  pick_owner,
   output logic [SHARER_W-1:0] pick_sharers
);
   always_comb begin
      if (cache_hit) begin
         pick_state   = cache_state;
         pick_owner   = cache_owner;
         pick_sharers = cache_sharers;
      end else if (tshr_hit) begin
         pick_state   = tshr_state;
         pick_owner   = tshr_owner;
         pick_sharers = tshr_sharers;
      end else if (is_repl) begin
         pick_state   = msg_state;
         pick_owner   = msg_owner;
         pick_sharers = msg_sharers;
      end else begin
         pick_state   = ST_N;
         pick_owner   = '0;
         pick_sharers = '0;
      end
   end
endmodule

// File: rtl/coh_cmd_decode.sv
module coh_cmd_decode
   import coh_dec_pkg::*;
(
   input  logic    valid,
   input  logic    cur_stable,
   input  logic    nxt_stable,
   input  logic    hit,
   input  logic    way_valid,
   input  logic    info_en,
   input  logic    store_data,
   input  logic    inval_way,
   output wr_cmd_t cmd
);
   logic wr_req;
   logic t_alloc, t_release, t_modify;
   logic c_update, c_alloc;

   assign wr_req    = info_en | store_data;

   // transaction table side: follows stable <-> transient crossings
   assign t_alloc   = valid &  cur_stable & ~nxt_stable;
   assign t_release = valid & ~cur_stable &  nxt_stable;
   assign t_modify  = valid & ~cur_stable & ~nxt_stable & info_en;

   // array side: mirror of the table side
   assign c_update  = valid & cur_stable & nxt_stable & hit & wr_req;
   assign c_alloc   = valid & nxt_stable & wr_req
                    & ~(t_release & inval_way) & ~c_update;

   always_comb begin
      cmd               = '0;
      cmd.tshr_alloc    = t_alloc;
      cmd.tshr_release  = t_release;
      cmd.tshr_modify   = t_modify;
      cmd.cache_update  = c_update;
      cmd.cache_alloc   = c_alloc;
      cmd.cache_dealloc = t_alloc & hit;
      // victim overwritten in place; old line goes to the queue
      cmd.repl_enq      = c_alloc & ~hit & way_valid;
   end
endmodule

// File: rtl/coh_state_decoder.sv
module coh_state_decoder
   import coh_dec_pkg::*;
#(
   parameter int                    OWNER_W     = 4,
   parameter int                    SHARER_W    = 8,
   parameter bit                    REG_OUT     = 1'b1,
   parameter logic [NUM_STATES-1:0] STABLE_MASK = DEFAULT_STABLE_MASK
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                msg_valid,
   input  logic                cache_hit,
   input  logic                way_valid,
   input  logic                tshr_hit,
   input  logic                is_repl,
   input  logic [2:0]          cache_state,
   input  logic [OWNER_W-1:0]  cache_owner,
   input  logic [SHARER_W-1:0] cache_sharers,
   input  logic [2:0]          tshr_state,
   input  logic [OWNER_W-1:0]  tshr_owner,
   input  logic [SHARER_W-1:0] tshr_sharers,
   input  logic [2:0]          msg_state,
   input  logic [OWNER_W-1:0]  msg_owner,
   input  logic [SHARER_W-1:0] msg_sharers,
   input  logic [2:0]          next_state,
   input  logic                info_en,
   input  logic                store_data,
   input  logic                inval_way,
   output logic [2:0]          sel_state,
   output logic [OWNER_W-1:0]  sel_owner,
   output logic [SHARER_W-1:0] sel_sharers,
   output logic                tshr_alloc,
   output logic                tshr_release,
   output logic                tshr_modify,
   output logic                cache_alloc,
   output logic                cache_dealloc,
   output logic                cache_update,
   output logic                repl_enq
);
   localparam int SEL_W = STATE_W + OWNER_W + SHARER_W;

   generate
      if (OWNER_W < 1) begin : g_bad_owner
         $error("OWNER_W must be at least 1");
      end
      if (SHARER_W < 1) begin : g_bad_sharer
         $error("SHARER_W must be at least 1");
      end
      if (STABLE_MASK[0] != 1'b1) begin : g_bad_n
         $error("state N must be stable");
      end
      if (&STABLE_MASK) begin : g_bad_mask
         $error("at least one transient state is required");
      end
   endgenerate

   logic [STATE_W-1:0]  pick_state;
   logic [OWNER_W-1:0]  pick_owner;
   logic [SHARER_W-1:0] pick_sharers;
   logic                cur_stable, nxt_stable;
   wr_cmd_t             cmd_d;

   coh_state_select #(.OWNER_W(OWNER_W), .SHARER_W(SHARER_W)) u_sel (
      .cache_hit     (cache_hit),
      .tshr_hit      (tshr_hit),
      .is_repl       (is_repl),
      .cache_state   (cache_state),
      .cache_owner   (cache_owner),
      .cache_sharers (cache_sharers),
      .tshr_state    (tshr_state),
      .tshr_owner    (tshr_owner),
      .tshr_sharers  (tshr_sharers),
      .msg_state     (msg_state),
      .msg_owner     (msg_owner),
      .msg_sharers   (msg_sharers),
      .pick_state    (pick_state),
      .pick_owner    (pick_owner),
      .pick_sharers  (pick_sharers)
   );

   coh_stable_lut #(.STABLE_MASK(STABLE_MASK)) u_cur_lut (
      .code   (pick_state),
      .stable (cur_stable)
   );

   coh_stable_lut #(.STABLE_MASK(STABLE_MASK)) u_nxt_lut (
      .code   (next_state),
      .stable (nxt_stable)
   );

   coh_cmd_decode u_dec (
      .valid      (msg_valid),
      .cur_stable (cur_stable),
      .nxt_stable (nxt_stable),
      .hit        (cache_hit),
      .way_valid  (way_valid),
      .info_en    (info_en),
      .store_data (store_data),
      .inval_way  (inval_way),
      .cmd        (cmd_d)
   );

   logic [SEL_W-1:0] sel_d, sel_q;
   wr_cmd_t          cmd_q;

   assign sel_d = {pick_state, pick_owner, pick_sharers};

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               sel_q <= '0;
               cmd_q <= '0;
            end else begin
               sel_q <= sel_d;
               cmd_q <= cmd_d;
            end
         end
      end else begin : g_comb
         assign sel_q = sel_d;
         assign cmd_q = cmd_d;
      end
   endgenerate

   assign {sel_state, sel_owner, sel_sharers} = sel_q;
   assign tshr_alloc    = cmd_q.tshr_alloc;
   assign tshr_release  = cmd_q.tshr_release;
   assign tshr_modify   = cmd_q.tshr_modify;
   assign cache_alloc   = cmd_q.cache_alloc;
   assign cache_dealloc = cmd_q.cache_dealloc;
   assign cache_update  = cmd_q.cache_update;
   assign repl_enq      = cmd_q.repl_enq;
endmodule

// File: rtl/coh_state_decoder_chk.sv
module coh_state_decoder_chk #(
   parameter int OWNER_W  = 4,
   parameter int SHARER_W = 8,
   parameter bit REG_OUT  = 1'b1
) (
   input logic       clk,
   input logic       rst,
   input logic       msg_valid,
   input logic       cache_hit,
   input logic [2:0] cache_state,
   input logic [2:0] sel_state,
   input logic       tshr_alloc,
   input logic       tshr_release,
   input logic       tshr_modify,
   input logic       cache_alloc,
   input logic       cache_dealloc,
   input logic       cache_update,
   input logic       repl_enq
);
   assert_tshr_onehot_R9: assert property (@(posedge clk) disable iff (rst)
      $onehot0({tshr_alloc, tshr_release, tshr_modify}));

   assert_alloc_update_excl_R9: assert property (@(posedge clk) disable iff (rst)
      !(cache_alloc && cache_update));

   assert_dealloc_needs_tshr_R6: assert property (@(posedge clk) disable iff (rst)
      cache_dealloc |-> tshr_alloc);

   assert_enq_needs_alloc_R7: assert property (@(posedge clk) disable iff (rst)
      repl_enq |-> (cache_alloc && !cache_dealloc));

   generate
      if (REG_OUT) begin : g_seq
         assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
            !msg_valid |=> !(tshr_alloc || tshr_release || tshr_modify ||
                             cache_alloc || cache_dealloc || cache_update || repl_enq));

         assert_cache_first_R1: assert property (@(posedge clk) disable iff (rst)
            cache_hit |=> sel_state == $past(cache_state));
      end
   endgenerate
endmodule

bind coh_state_decoder coh_state_decoder_chk #(
   .OWNER_W(OWNER_W), .SHARER_W(SHARER_W), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/coh_state_decoder_bench.sv
module coh_state_decoder_bench;
   localparam int OW = 4;
   localparam int SW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          msg_valid, cache_hit, way_valid, tshr_hit, is_repl;
   logic [2:0]    cache_state, tshr_state, msg_state, next_state;
   logic [OW-1:0] cache_owner, tshr_owner, msg_owner;
   logic [SW-1:0] cache_sharers, tshr_sharers, msg_sharers;
   logic          info_en, store_data, inval_way;
   logic [2:0]    sel_state;
   logic [OW-1:0] sel_owner;
   logic [SW-1:0] sel_sharers;
   logic          tshr_alloc, tshr_release, tshr_modify;
   logic          cache_alloc, cache_dealloc, cache_update, repl_enq;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   coh_state_decoder #(.OWNER_W(OW), .SHARER_W(SW)) u_coh_state_decoder (.*);

   function automatic bit stable_f(input logic [2:0] s);
      return s < 3'd4;   // R2: 0..3 stable, 4..7 transient
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic zero_inputs();
      msg_valid = 0; cache_hit = 0; way_valid = 0; tshr_hit = 0; is_repl = 0;
      cache_state = 0; tshr_state = 0; msg_state = 0; next_state = 0;
      cache_owner = 0; tshr_owner = 0; msg_owner = 0;
      cache_sharers = 0; tshr_sharers = 0; msg_sharers = 0;
      info_en = 0; store_data = 0; inval_way = 0;
   endtask

   // expected values from the requirements; inputs captured before the edge
   task automatic apply_and_check();
      logic [2:0] es; logic [OW-1:0] eo; logic [SW-1:0] esh;
      bit cs, ns, wr, ta, tr, tm, cu, ca, cd, re;
      if (cache_hit)     begin es = cache_state; eo = cache_owner; esh = cache_sharers; end
      else if (tshr_hit) begin es = tshr_state;  eo = tshr_owner;  esh = tshr_sharers;  end
      else if (is_repl)  begin es = msg_state;   eo = msg_owner;   esh = msg_sharers;   end
      else               begin es = 3'd0;        eo = '0;          esh = '0;            end
      cs = stable_f(es); ns = stable_f(next_state);
      wr = info_en | store_data;
      ta = msg_valid &  cs & !ns;
      tr = msg_valid & !cs &  ns;
      tm = msg_valid & !cs & !ns & info_en;
      cu = msg_valid & cs & ns & cache_hit & wr;
      ca = msg_valid & ns & wr & !(tr & inval_way) & !cu;
      cd = ta & cache_hit;
      re = ca & !cache_hit & way_valid;
      @(negedge clk);
      chk("R1", "sel_state",   sel_state,   es);
      chk("R1", "sel_owner",   sel_owner,   eo);
      chk("R1", "sel_sharers", sel_sharers, esh);
      chk("R3", "tshr_alloc",   tshr_alloc,   ta);
      chk("R3", "tshr_release", tshr_release, tr);
      chk("R3", "tshr_modify",  tshr_modify,  tm);
      chk("R4", "cache_update", cache_update, cu);
      chk("R5", "cache_alloc",  cache_alloc,  ca);
      chk("R6", "cache_dealloc", cache_dealloc, cd);
      chk("R7", "repl_enq",     repl_enq,     re);
      chk("R9", "alloc_and_update", cache_alloc & cache_update, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      zero_inputs();
      msg_valid = 1; cache_hit = 1; cache_state = 3'd3; next_state = 3'd5; info_en = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8: reset state
      chk("R8", "reset sel_state", sel_state, 0);
      chk("R8", "reset strobes",
          {tshr_alloc, tshr_release, tshr_modify, cache_alloc,
           cache_dealloc, cache_update, repl_enq}, 0);
      rst = 0;
      zero_inputs();

      // R7: replacement push, miss on valid way, state N -> S with store
      msg_valid = 1; way_valid = 1; next_state = 3'd2; store_data = 1;
      apply_and_check();
      chk("R7", "directed repl_enq", repl_enq, 1);
      chk("R7", "directed no dealloc", cache_dealloc, 0);

      // R5: TSHR release with invalidate suppresses allocation
      zero_inputs();
      msg_valid = 1; tshr_hit = 1; tshr_state = 3'd6; next_state = 3'd0;
      info_en = 1; inval_way = 1; way_valid = 1;
      apply_and_check();
      chk("R5", "release+inval no alloc", cache_alloc, 0);
      chk("R3", "release fired", tshr_release, 1);

      // R6: hit on M going transient releases the cache line
      zero_inputs();
      msg_valid = 1; cache_hit = 1; cache_state = 3'd3; next_state = 3'd5; info_en = 1;
      apply_and_check();
      chk("R6", "dealloc on hit", cache_dealloc, 1);

      // R8: invalid message with everything else active is ignored
      zero_inputs();
      cache_hit = 1; cache_state = 3'd2; next_state = 3'd4; info_en = 1; store_data = 1;
      way_valid = 1; tshr_hit = 1;
      apply_and_check();
      chk("R8", "idle strobes",
          {tshr_alloc, tshr_release, tshr_modify, cache_alloc,
           cache_dealloc, cache_update, repl_enq}, 0);

      // R1: all sources present, cache wins; then replacement-only source
      zero_inputs();
      msg_valid = 1; cache_hit = 1; tshr_hit = 1; is_repl = 1;
      cache_state = 3'd1; tshr_state = 3'd7; msg_state = 3'd3; cache_owner = 4'd9;
      apply_and_check();
      chk("R1", "cache priority", sel_state, 1);
      zero_inputs();
      msg_valid = 1; is_repl = 1; msg_state = 3'd3; msg_owner = 4'd6; msg_sharers = 8'h5a;
      apply_and_check();
      chk("R1", "message source", sel_owner, 6);

      // R4 / R2: random stimulus, biased toward stable next states
      for (int i = 0; i < 600; i++) begin
         msg_valid    = ($urandom % 8) != 0;
         cache_hit    = $urandom % 2;
         way_valid    = $urandom % 2;
         tshr_hit     = $urandom % 2;
         is_repl      = $urandom % 2;
         cache_state  = 3'($urandom);
         tshr_state   = 3'($urandom);
         msg_state    = 3'($urandom);
         next_state   = (($urandom % 3) != 0) ? 3'($urandom % 4) : 3'($urandom);
         cache_owner  = OW'($urandom);
         tshr_owner   = OW'($urandom);
         msg_owner    = OW'($urandom);
         cache_sharers = SW'($urandom);
         tshr_sharers  = SW'($urandom);
         msg_sharers   = SW'($urandom);
         info_en      = ($urandom % 3) != 0;
         store_data   = $urandom % 2;
         inval_way    = $urandom % 2;
         apply_and_check();
      end
      finish_run();
   end
endmodule